// File: doc/BRIEF.md
# Interrupt Request and Flag Controller

This block produces the interrupt requests of a small 8-bit microcontroller. It has three sources. The first is one external interrupt pin with a selectable sense. The second is a shared pin-change detector over a group of I/O pins. The third is the overflow flag of a timer that lives elsewhere. All pins pass through a two-stage synchronizer. An edge or change is found by comparing the current synchronized sample with the one before it.

Software reaches four byte-wide registers over a simple I/O bus with address, write data, write strobe and registered read data:

- a flag register;
- a mask register for the pin sources;
- a timer mask register;
- a sense-control register.

A pending source becomes a request only when its enable and the global interrupt bit are both set. When several sources are pending, the one with the lowest fixed vector is presented. The CPU answers with a one-cycle acknowledge that carries the vector. The acknowledge clears only the matching flag, or for the timer it returns a clear pulse.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req` is 0 and `irq_vec` is 0.
- R2: Register reads return 0 for all reserved bits, as follows.
  - 0x3B: bit 6 is the external enable and bit 5 is the pin-change enable.
  - 0x39: bit 1 is the timer overflow enable.
  - 0x35: bits 1:0 are the sense code.
  - 0x3A: bit 6 is the external flag and bit 5 is the pin-change flag. Writing 1 to a flag bit never sets it.
  - `io_rdata` shows the register addressed in the previous cycle.
- R3: The sense code selects the edge that sets the external flag: 3 sets it on a rising edge only, 2 on a falling edge only, and 1 on either edge.
- R4: With sense code 0 (low level), the external flag reads 0. The external source is pending while the synchronized pin is low.
- R5: A level change on any one of the `pc_pins` sets the single pin-change flag (0x3A bit 5).
- R6: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: A source raises `irq_req` only when its enable bit is 1 and `gie` is 1. Otherwise `irq_req` stays 0.
- R8: The vector codes are 1 for external, 2 for pin change and 3 for timer overflow. When several sources are pending, `irq_vec` shows the lowest code. It shows 0 when nothing is pending.
- R9: An acknowledge with vector 1 clears only the external flag, and vector 2 clears only the pin-change flag. Vector 3 produces a one-cycle `tmr_ovf_ack` pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O register address |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe |
| io_rdata | output | 8 | Registered read data |
| ext_pin | input | 1 | External interrupt pin |
| pc_pins | input | NPC | Monitored pin-change group |
| tmr_ovf_flag | input | 1 | Overflow flag held by the timer |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | One-cycle CPU acknowledge |
| ack_vec | input | VEC_W | Vector being acknowledged |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | VEC_W | Registered winning vector |
| tmr_ovf_ack | output | 1 | Pulse that clears the timer flag |

## Verification
The bench drives each sense code with both edge directions. A detector that ignores the sense code, or that sets the flag on the wrong edge, leaves a flag where none is expected or misses one.

Level mode is checked with the flag read back as zero while the request follows the pin. A design that latches the flag in that mode would show bit 6 set.

Write-zero and write-one to the flag register are both exercised. Every source is made pending at once, and each acknowledge is checked to step the vector from 1 to 2 to 3 without touching other flags. A wrong priority order or a clear that touches other flags shows up as a wrong vector or a missing flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_ANY  = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_e;

  localparam int NSRC    = 3;
  localparam int VEC_W   = $clog2(NSRC + 1);
  localparam int BIT_EXT = 6;
  localparam int BIT_PC  = 5;
  localparam int BIT_TOV = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] p
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      s    <= '0;
      p    <= '0;
    end else begin
      meta <= d;
      s    <= meta;
      p    <= s;
    end
  end
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
  import irq_pkg::*;
(
  input  sense_e sense,
  input  logic   cur,
  input  logic   prev,
  output logic   edge_evt,
  output logic   level_req
);
  logic rise, fall;

  always_comb begin
    rise      = cur & ~prev;
    fall      = ~cur & prev;
    level_req = ~cur;
    unique case (sense)
      SENSE_RISE: edge_evt = rise;
      SENSE_FALL: edge_evt = fall;
      SENSE_ANY:  edge_evt = rise | fall;
      default:    edge_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 3,
  localparam int VW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  output logic          req,
  output logic [VW-1:0] vec
);
  logic [VW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) pick = VW'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else begin
      req <= |pend;
      vec <= pick;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int NPC    = 6,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] A_FLAG  = 6'h3A,
  parameter logic [ADDR_W-1:0] A_PMASK = 6'h3B,
  parameter logic [ADDR_W-1:0] A_TMASK = 6'h39,
  parameter logic [ADDR_W-1:0] A_SENSE = 6'h35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_we,
  output logic [7:0]        io_rdata,
  input  logic              ext_pin,
  input  logic [NPC-1:0]    pc_pins,
  input  logic              tmr_ovf_flag,
  input  logic              gie,
  input  logic              ack,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              tmr_ovf_ack
);
  logic [NPC:0] smp, prv;
  logic         ext_evt, ext_low, pc_evt;
  sense_e       sense_q;
  logic         ext_en_q, pc_en_q, tov_en_q;
  logic         intf_q, pcif_q;
  logic         wr_flag, wr_pmask, wr_tmask, wr_sense;
  logic         ack_ext, ack_pc, ack_tov;
  logic [NSRC-1:0] pend;
  logic [7:0]   rd_mux;

  irq_sync #(.W(NPC + 1)) u_sync (
    .clk(clk), .rst(rst), .d({pc_pins, ext_pin}), .s(smp), .p(prv)
  );

  irq_ext_sense u_sense (
    .sense(sense_q), .cur(smp[0]), .prev(prv[0]),
    .edge_evt(ext_evt), .level_req(ext_low)
  );

  assign pc_evt   = |(smp[NPC:1] ^ prv[NPC:1]);
  assign wr_flag  = io_we && (io_addr == A_FLAG);
  assign wr_pmask = io_we && (io_addr == A_PMASK);
  assign wr_tmask = io_we && (io_addr == A_TMASK);
  assign wr_sense = io_we && (io_addr == A_SENSE);
  assign ack_ext  = ack && (ack_vec == VEC_W'(1));
  assign ack_pc   = ack && (ack_vec == VEC_W'(2));
  assign ack_tov  = ack && (ack_vec == VEC_W'(3));

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q     <= SENSE_LOW;
      ext_en_q    <= 1'b0;
      pc_en_q     <= 1'b0;
      tov_en_q    <= 1'b0;
      intf_q      <= 1'b0;
      pcif_q      <= 1'b0;
      tmr_ovf_ack <= 1'b0;
      io_rdata    <= 8'h00;
    end else begin
      if (wr_sense) sense_q <= sense_e'(io_wdata[1:0]);
      if (wr_pmask) begin
        ext_en_q <= io_wdata[BIT_EXT];
        pc_en_q  <= io_wdata[BIT_PC];
      end
      if (wr_tmask) tov_en_q <= io_wdata[BIT_TOV];

      if (sense_q == SENSE_LOW) intf_q <= 1'b0;
      else if (ext_evt) intf_q <= 1'b1;
      else if ((wr_flag && io_wdata[BIT_EXT]) || ack_ext) intf_q <= 1'b0;

      if (pc_evt) pcif_q <= 1'b1;
      else if ((wr_flag && io_wdata[BIT_PC]) || ack_pc) pcif_q <= 1'b0;

      tmr_ovf_ack <= ack_tov;
      io_rdata    <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (io_addr == A_FLAG) begin
      rd_mux[BIT_EXT] = intf_q;
      rd_mux[BIT_PC]  = pcif_q;
    end else if (io_addr == A_PMASK) begin
      rd_mux[BIT_EXT] = ext_en_q;
      rd_mux[BIT_PC]  = pc_en_q;
    end else if (io_addr == A_TMASK) begin
      rd_mux[BIT_TOV] = tov_en_q;
    end else if (io_addr == A_SENSE) begin
      rd_mux[1:0] = sense_q;
    end
  end

  always_comb begin
    pend[0] = ext_en_q && ((sense_q == SENSE_LOW) ? ext_low : intf_q);
    pend[1] = pc_en_q && pcif_q;
    pend[2] = tov_en_q && tmr_ovf_flag;
    pend    = pend & {NSRC{gie}};
  end

  irq_arbiter #(.N(NSRC)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .req(irq_req), .vec(irq_vec)
  );
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             gie,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             ack,
  input logic [VEC_W-1:0] ack_vec,
  input logic             tmr_ovf_ack,
  input sense_e           sense_q,
  input logic             intf_q
);
  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));

  // R8
  vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec != '0));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0));

  // R4
  level_flag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sense_q == SENSE_LOW) |-> !intf_q);

  // R9
  tov_ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf_ack |-> $past(ack && (ack_vec == VEC_W'(3))));
endmodule

bind irq_flag_ctrl irq_flag_chk u_chk (
  .clk(clk), .rst(rst), .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec),
  .ack(ack), .ack_vec(ack_vec), .tmr_ovf_ack(tmr_ovf_ack),
  .sense_q(sense_q), .intf_q(intf_q)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  import irq_pkg::*;
  localparam int NPC = 6;
  localparam logic [5:0] A_FLAG = 6'h3A, A_PMASK = 6'h3B, A_TMASK = 6'h39, A_SENSE = 6'h35;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic io_we = 1'b0, ext_pin = 1'b0, tmr_ovf_flag = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [NPC-1:0] pc_pins = '0;
  logic [VEC_W-1:0] ack_vec = '0, irq_vec;
  logic irq_req, tmr_ovf_ack;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl #(.NPC(NPC)) dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we),
    .io_rdata(io_rdata), .ext_pin(ext_pin), .pc_pins(pc_pins),
    .tmr_ovf_flag(tmr_ovf_flag), .gie(gie), .ack(ack), .ack_vec(ack_vec),
    .irq_req(irq_req), .irq_vec(irq_vec), .tmr_ovf_ack(tmr_ovf_ack)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    @(negedge clk);
    d = io_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic do_ack(input logic [VEC_W-1:0] v, output logic pulse);
    @(negedge clk);
    ack = 1'b1; ack_vec = v;
    @(negedge clk);
    ack = 1'b0; ack_vec = '0;
    pulse = tmr_ovf_ack;
  endtask

  task automatic t_reset;
    check("R1 irq_req", {7'd0, irq_req}, 8'h00);
    check("R1 irq_vec", {6'd0, irq_vec}, 8'h00);
    rd_chk("R1 flag", A_FLAG, 8'h00);
    rd_chk("R1 pmask", A_PMASK, 8'h00);
    rd_chk("R1 tmask", A_TMASK, 8'h00);
    rd_chk("R1 sense", A_SENSE, 8'h00);
  endtask

  task automatic t_regs;
    wr(A_PMASK, 8'hFF); rd_chk("R2 pmask", A_PMASK, 8'h60);
    wr(A_TMASK, 8'hFF); rd_chk("R2 tmask", A_TMASK, 8'h02);
    wr(A_SENSE, 8'hFF); rd_chk("R2 sense", A_SENSE, 8'h03);
    wr(A_FLAG, 8'hFF);  rd_chk("R2 flag no set", A_FLAG, 8'h00);
    wr(A_PMASK, 8'h00); wr(A_TMASK, 8'h00);
  endtask

  task automatic t_edges;
    wr(A_SENSE, 8'h03);
    ext_pin = 1'b1; idle(6); rd_chk("R3 rise on rise", A_FLAG, 8'h40);
    wr(A_FLAG, 8'h40);
    ext_pin = 1'b0; idle(6); rd_chk("R3 rise ignores fall", A_FLAG, 8'h00);
    wr(A_SENSE, 8'h02);
    ext_pin = 1'b1; idle(6); rd_chk("R3 fall ignores rise", A_FLAG, 8'h00);
    ext_pin = 1'b0; idle(6); rd_chk("R3 fall on fall", A_FLAG, 8'h40);
    wr(A_FLAG, 8'h40);
    wr(A_SENSE, 8'h01);
    ext_pin = 1'b1; idle(6); rd_chk("R3 any on rise", A_FLAG, 8'h40);
    wr(A_FLAG, 8'h40);
    ext_pin = 1'b0; idle(6); rd_chk("R3 any on fall", A_FLAG, 8'h40);
    wr(A_FLAG, 8'h40);
  endtask

  task automatic t_level;
    ext_pin = 1'b1; idle(6);
    wr(A_SENSE, 8'h00);
    wr(A_PMASK, 8'h40);
    gie = 1'b1;
    idle(4);
    check("R4 high no req", {7'd0, irq_req}, 8'h00);
    ext_pin = 1'b0; idle(6);
    check("R4 low req", {7'd0, irq_req}, 8'h01);
    check("R4 low vec", {6'd0, irq_vec}, 8'h01);
    rd_chk("R4 flag reads zero", A_FLAG, 8'h00);
    ext_pin = 1'b1; idle(6);
    check("R4 released", {7'd0, irq_req}, 8'h00);
    gie = 1'b0;
    wr(A_PMASK, 8'h00);
  endtask

  task automatic t_pc;
    pc_pins[2] = 1'b1; idle(6); rd_chk("R5 pin2 change", A_FLAG, 8'h20);
    wr(A_FLAG, 8'h00); rd_chk("R6 write zero keeps", A_FLAG, 8'h20);
    wr(A_FLAG, 8'h20); rd_chk("R6 write one clears", A_FLAG, 8'h00);
    pc_pins[NPC-1] = 1'b1; idle(6); rd_chk("R5 top pin change", A_FLAG, 8'h20);
  endtask

  task automatic t_gate;
    wr(A_PMASK, 8'h20);
    idle(4);
    check("R7 gie off", {7'd0, irq_req}, 8'h00);
    gie = 1'b1; idle(3);
    check("R7 gie on", {7'd0, irq_req}, 8'h01);
    check("R8 pc vec", {6'd0, irq_vec}, 8'h02);
    wr(A_PMASK, 8'h00); idle(2);
    check("R7 mask off", {7'd0, irq_req}, 8'h00);
    gie = 1'b0;
    wr(A_FLAG, 8'h20);
  endtask

  task automatic t_prio;
    logic p;
    ext_pin = 1'b0; idle(6);
    wr(A_SENSE, 8'h03);
    ext_pin = 1'b1; pc_pins[0] = 1'b1; tmr_ovf_flag = 1'b1; idle(6);
    wr(A_PMASK, 8'h60); wr(A_TMASK, 8'h02);
    gie = 1'b1; idle(3);
    check("R8 all pending vec", {6'd0, irq_vec}, 8'h01);
    do_ack(VEC_W'(1), p);
    check("R9 ack1 no tov pulse", {7'd0, p}, 8'h00);
    idle(2);
    check("R8 next vec", {6'd0, irq_vec}, 8'h02);
    rd_chk("R9 ack1 keeps pc flag", A_FLAG, 8'h20);
    do_ack(VEC_W'(2), p);
    idle(2);
    check("R8 timer vec", {6'd0, irq_vec}, 8'h03);
    rd_chk("R9 ack2 cleared pc", A_FLAG, 8'h00);
    do_ack(VEC_W'(3), p);
    check("R9 tov pulse", {7'd0, p}, 8'h01);
    tmr_ovf_flag = 1'b0;
    idle(1);
    check("R9 pulse one cycle", {7'd0, tmr_ovf_ack}, 8'h00);
    idle(2);
    check("R8 none pending", {6'd0, irq_vec}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_edges();
    t_level();
    t_pc();
    t_gate();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule